// File: doc/BRIEF.md
# Register Rename Table with Free List

This block performs explicit register renaming for a processor front end. Each instruction names architectural registers. The block holds a translation table that maps each architectural register to one register in a larger physical pool, and a bit-vector free list that tracks which physical registers are unassigned. For every instruction it accepts, it reads the physical registers behind the two source operands from the current table. When the instruction writes a register, the block also hands out a fresh physical register for the destination and returns the mapping that the destination had before. Later pipeline stages use that old mapping to release the register once no in-flight instruction still reads it. Because every write gets a new physical register, write-after-read and write-after-write conflicts disappear and only true read-after-write dependences remain.

When no physical register is free, a rename that needs a destination is held off with a stall. Renames without a destination still go through. Released registers return to the free list through a separate free port. A release and an allocation in the same cycle are both carried out. The block keeps one snapshot of the table and the free list, taken when a branch is renamed. On a mispredict or an exception, a restore brings the table back to that snapshot in a single cycle. Registers released after the snapshot stay free after the restore.

Top module: `rename_unit`

## Requirements
- R1: After reset, architectural register i maps to physical register i. Physical registers NUM_ARCH to NUM_PHYS-1 are free, and the first destination allocation returns physical register NUM_ARCH.
- R2: `src1_p_o` and `src2_p_o` show the current mapping of `src1_i` and `src2_i`. They are combinational and read the table before any update made in the same cycle.
- R3: An accepted rename with `has_dst_i`=1 returns on `dst_p_o` the lowest-numbered free physical register and removes it from the free list. It returns on `old_p_o` the previous mapping of `dst_i`. From the next cycle on, `dst_i` maps to the new register.
- R4: A rename with `has_dst_i`=0 allocates nothing, leaves the free list unchanged, and is accepted even when the free list is empty.
- R5: `stall_o` is 1 exactly when `ren_valid_i`=1, `has_dst_i`=1 and the free list is empty. A stalled rename has `ren_ack_o`=0 and changes neither the table nor the free list.
- R6: When `free_valid_i`=1, `free_p_i` is free from the next cycle on. A release and an allocation in the same cycle are both carried out. A register released in a cycle can be allocated from the following cycle on, not in the same cycle.
- R7: `ckpt_take_i` records the table and free list as they stand after the updates of that same cycle, including the rename accepted in that cycle.
- R8: `restore_i` puts the recorded table back in one cycle. The free list becomes the recorded free list plus every register released since the snapshot, including one released in the restore cycle. No rename is accepted in the restore cycle.
- R9: `ren_ack_o` = `ren_valid_i` AND NOT `stall_o` AND NOT `restore_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ren_valid_i | input | 1 | Rename request |
| has_dst_i | input | 1 | Instruction writes a destination register |
| dst_i | input | $clog2(NUM_ARCH) | Architectural destination |
| src1_i | input | $clog2(NUM_ARCH) | Architectural source 1 |
| src2_i | input | $clog2(NUM_ARCH) | Architectural source 2 |
| src1_p_o | output | $clog2(NUM_PHYS) | Physical register for source 1 |
| src2_p_o | output | $clog2(NUM_PHYS) | Physical register for source 2 |
| dst_p_o | output | $clog2(NUM_PHYS) | Newly allocated physical destination |
| old_p_o | output | $clog2(NUM_PHYS) | Previous mapping of the destination |
| stall_o | output | 1 | Rename held: no free physical register |
| ren_ack_o | output | 1 | Rename accepted this cycle |
| free_valid_i | input | 1 | Release request |
| free_p_i | input | $clog2(NUM_PHYS) | Physical register to release |
| ckpt_take_i | input | 1 | Record snapshot (post-update state) |
| restore_i | input | 1 | Restore snapshot |

## Verification
The bench uses the default sizes of 32 architectural and 64 physical registers. With these sizes, 32 back-to-back allocations drain the free list from register 32 up to 63, so the empty-list stall is reached quickly. At the empty point the bench checks a rename without a destination that still goes through. It also checks a release and an allocation landing in the same cycle. The checkpoint sequence releases a register after the snapshot and then restores. It confirms that this register is the first one handed out afterwards, and that the rename recorded in the snapshot cycle survives the restore.

// File: rtl/rename_pkg.sv
package rename_pkg;
  localparam int unsigned DEF_NUM_ARCH = 32;
  localparam int unsigned DEF_NUM_PHYS = 64;
endpackage

// File: rtl/rename_map_table.sv
module rename_map_table #(
  parameter int unsigned NUM_ARCH = 32,
  parameter int unsigned NUM_PHYS = 64,
  localparam int unsigned AW = $clog2(NUM_ARCH),
  localparam int unsigned PW = $clog2(NUM_PHYS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] rd1_idx_i,
  output logic [PW-1:0] rd1_p_o,
  input  logic [AW-1:0] rd2_idx_i,
  output logic [PW-1:0] rd2_p_o,
  input  logic [AW-1:0] rd_old_idx_i,
  output logic [PW-1:0] rd_old_p_o,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_idx_i,
  input  logic [PW-1:0] wr_p_i,
  input  logic          ckpt_take_i,
  input  logic          restore_i
);
  logic [PW-1:0] map_q  [NUM_ARCH];
  logic [PW-1:0] map_d  [NUM_ARCH];
  logic [PW-1:0] ckpt_q [NUM_ARCH];

  assign rd1_p_o    = map_q[rd1_idx_i];
  assign rd2_p_o    = map_q[rd2_idx_i];
  assign rd_old_p_o = map_q[rd_old_idx_i];

  always_comb begin
    map_d = map_q;
    if (restore_i)    map_d = ckpt_q;
    else if (wr_en_i) map_d[wr_idx_i] = wr_p_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_ARCH; i++) begin
        map_q[i]  <= PW'(i);
        ckpt_q[i] <= PW'(i);
      end
    end else begin
      map_q <= map_d;
      // snapshot includes this cycle's write
      if (ckpt_take_i && !restore_i) ckpt_q <= map_d;
    end
  end
endmodule

// File: rtl/rename_free_list.sv
module rename_free_list #(
  parameter int unsigned NUM_ARCH = 32,
  parameter int unsigned NUM_PHYS = 64,
  localparam int unsigned PW = $clog2(NUM_PHYS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                alloc_en_i,
  output logic [PW-1:0]       alloc_p_o,
  output logic                empty_o,
  input  logic                free_en_i,
  input  logic [PW-1:0]       free_p_i,
  input  logic                ckpt_take_i,
  input  logic                restore_i,
  output logic [NUM_PHYS-1:0] free_vec_o
);
  logic [NUM_PHYS-1:0] free_q, free_d, ckpt_q, ckpt_d;
  logic [NUM_PHYS-1:0] ret_vec, take_vec, rst_vec;

  for (genvar g = 0; g < NUM_PHYS; g++) begin : g_rst
    assign rst_vec[g] = (g >= NUM_ARCH);
  end

  // lowest-index free register
  always_comb begin
    alloc_p_o = '0;
    for (int i = NUM_PHYS - 1; i >= 0; i--) begin
      if (free_q[i]) alloc_p_o = PW'(i);
    end
  end

  assign empty_o = ~|free_q;

  always_comb begin
    ret_vec  = '0;
    take_vec = '0;
    ret_vec[free_p_i]   = free_en_i;
    take_vec[alloc_p_o] = alloc_en_i;
  end

  always_comb begin
    if (restore_i) free_d = ckpt_q | ret_vec;
    else           free_d = (free_q & ~take_vec) | ret_vec;
    // releases after the snapshot must survive a restore
    if (ckpt_take_i && !restore_i) ckpt_d = free_d;
    else                           ckpt_d = ckpt_q | ret_vec;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      free_q <= rst_vec;
      ckpt_q <= rst_vec;
    end else begin
      free_q <= free_d;
      ckpt_q <= ckpt_d;
    end
  end

  assign free_vec_o = free_q;
endmodule

// File: rtl/rename_unit.sv
module rename_unit #(
  parameter int unsigned NUM_ARCH = rename_pkg::DEF_NUM_ARCH,
  parameter int unsigned NUM_PHYS = rename_pkg::DEF_NUM_PHYS,
  localparam int unsigned AW = $clog2(NUM_ARCH),
  localparam int unsigned PW = $clog2(NUM_PHYS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ren_valid_i,
  input  logic          has_dst_i,
  input  logic [AW-1:0] dst_i,
  input  logic [AW-1:0] src1_i,
  input  logic [AW-1:0] src2_i,
  output logic [PW-1:0] src1_p_o,
  output logic [PW-1:0] src2_p_o,
  output logic [PW-1:0] dst_p_o,
  output logic [PW-1:0] old_p_o,
  output logic          stall_o,
  output logic          ren_ack_o,
  input  logic          free_valid_i,
  input  logic [PW-1:0] free_p_i,
  input  logic          ckpt_take_i,
  input  logic          restore_i
);
  logic                empty;
  logic                alloc_en;
  logic [NUM_PHYS-1:0] free_vec;

  assign stall_o   = ren_valid_i & has_dst_i & empty;
  assign ren_ack_o = ren_valid_i & ~stall_o & ~restore_i;
  assign alloc_en  = ren_ack_o & has_dst_i;

  rename_map_table #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_map (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd1_idx_i   (src1_i),
    .rd1_p_o     (src1_p_o),
    .rd2_idx_i   (src2_i),
    .rd2_p_o     (src2_p_o),
    .rd_old_idx_i(dst_i),
    .rd_old_p_o  (old_p_o),
    .wr_en_i     (alloc_en),
    .wr_idx_i    (dst_i),
    .wr_p_i      (dst_p_o),
    .ckpt_take_i (ckpt_take_i),
    .restore_i   (restore_i)
  );

  rename_free_list #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_free (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .alloc_en_i (alloc_en),
    .alloc_p_o  (dst_p_o),
    .empty_o    (empty),
    .free_en_i  (free_valid_i),
    .free_p_i   (free_p_i),
    .ckpt_take_i(ckpt_take_i),
    .restore_i  (restore_i),
    .free_vec_o (free_vec)
  );
endmodule

// File: rtl/rename_unit_chk.sv
module rename_unit_chk #(
  parameter int unsigned NUM_PHYS = 64,
  localparam int unsigned PW = $clog2(NUM_PHYS)
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                ren_valid_i,
  input logic                has_dst_i,
  input logic [PW-1:0]       dst_p_o,
  input logic                stall_o,
  input logic                ren_ack_o,
  input logic                free_valid_i,
  input logic [PW-1:0]       free_p_i,
  input logic                restore_i,
  input logic [NUM_PHYS-1:0] free_vec
);
  // R5
  stall_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> !ren_ack_o);
  // R5
  stall_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (free_vec == '0));
  // R8
  restore_rejects_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_i |-> !ren_ack_o);
  // R3
  alloc_from_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ren_ack_o && has_dst_i) |-> free_vec[dst_p_o]);
  // R3
  alloc_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ren_ack_o && has_dst_i && !(free_valid_i && free_p_i == dst_p_o))
      |=> !free_vec[$past(dst_p_o)]);
  // R6
  free_returns_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_valid_i |=> free_vec[$past(free_p_i)]);
  // R4
  nodst_keeps_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ren_valid_i && !has_dst_i && !free_valid_i && !restore_i)
      |=> ($countones(free_vec) == $past($countones(free_vec))));
endmodule

bind rename_unit rename_unit_chk #(.NUM_PHYS(NUM_PHYS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ren_valid_i (ren_valid_i),
  .has_dst_i   (has_dst_i),
  .dst_p_o     (dst_p_o),
  .stall_o     (stall_o),
  .ren_ack_o   (ren_ack_o),
  .free_valid_i(free_valid_i),
  .free_p_i    (free_p_i),
  .restore_i   (restore_i),
  .free_vec    (free_vec)
);

// File: tb/rename_unit_bench.sv
`timescale 1ns/1ps
module rename_unit_bench;
  localparam int AW = 5;
  localparam int PW = 6;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ren_valid, has_dst, free_valid, ckpt_take, restore;
  logic [AW-1:0] dst, src1, src2;
  logic [PW-1:0] free_p;
  logic [PW-1:0] src1_p, src2_p, dst_p, old_p;
  logic stall, ack;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  rename_unit u_rename_unit (
    .clk_i(clk), .rst_ni(rst_ni),
    .ren_valid_i(ren_valid), .has_dst_i(has_dst), .dst_i(dst),
    .src1_i(src1), .src2_i(src2),
    .src1_p_o(src1_p), .src2_p_o(src2_p), .dst_p_o(dst_p), .old_p_o(old_p),
    .stall_o(stall), .ren_ack_o(ack),
    .free_valid_i(free_valid), .free_p_i(free_p),
    .ckpt_take_i(ckpt_take), .restore_i(restore)
  );

  typedef struct packed {
    logic          has;
    logic [AW-1:0] d, s1, s2;
    logic [PW-1:0] e1, e2, ed, eo;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{1'b1, 5'd1,  5'd2,  5'd3,  6'd2,  6'd3,  6'd32, 6'd1 },
    '{1'b1, 5'd4,  5'd1,  5'd1,  6'd32, 6'd32, 6'd33, 6'd4 },
    '{1'b1, 5'd1,  5'd1,  5'd4,  6'd32, 6'd33, 6'd34, 6'd32},
    '{1'b0, 5'd5,  5'd1,  5'd5,  6'd34, 6'd5,  6'd0,  6'd0 },
    '{1'b1, 5'd0,  5'd4,  5'd31, 6'd33, 6'd31, 6'd35, 6'd0 },
    '{1'b1, 5'd31, 5'd31, 5'd0,  6'd31, 6'd35, 6'd36, 6'd31}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic h, input int d, input int s1,
                       input int s2, input logic fv, input int fp,
                       input logic ck, input logic rs);
    @(negedge clk);
    ren_valid = v; has_dst = h; dst = AW'(d); src1 = AW'(s1); src2 = AW'(s2);
    free_valid = fv; free_p = PW'(fp); ckpt_take = ck; restore = rs;
    #1;
  endtask

  task automatic do_reset();
    ren_valid = 0; has_dst = 0; dst = '0; src1 = '0; src2 = '0;
    free_valid = 0; free_p = '0; ckpt_take = 0; restore = 0;
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    do_reset();
    // R1 reset mapping and first allocation
    drive(0, 1, 0, 7, 31, 0, 0, 0, 0);
    check("R1 src1 map", src1_p, 7);
    check("R1 src2 map", src2_p, 31);
    check("R1 first alloc", dst_p, 32);
    check("R9 idle ack", ack, 0);
    check("R5 idle stall", stall, 0);

    // vector table: R2 R3 R4
    for (int k = 0; k < 6; k++) begin
      drive(1, VEC[k].has, VEC[k].d, VEC[k].s1, VEC[k].s2, 0, 0, 0, 0);
      check("R2 src1", src1_p, VEC[k].e1);
      check("R2 src2", src2_p, VEC[k].e2);
      check("R9 ack", ack, 1);
      if (VEC[k].has) begin
        check("R3 dst", dst_p, VEC[k].ed);
        check("R3 old", old_p, VEC[k].eo);
      end
    end

    // drain free list
    do_reset();
    for (int k = 0; k < 32; k++) begin
      drive(1, 1, k, 0, 0, 0, 0, 0, 0);
      check("R3 drain dst", dst_p, 32 + k);
      check("R3 drain old", old_p, k);
      check("R9 drain ack", ack, 1);
    end
    drive(1, 1, 1, 0, 0, 0, 0, 0, 0);
    check("R5 empty stall", stall, 1);
    check("R5 empty ack", ack, 0);
    drive(1, 0, 0, 1, 0, 0, 0, 0, 0);
    check("R4 nodst no stall", stall, 0);
    check("R4 nodst ack", ack, 1);
    check("R5 table unchanged", src1_p, 33);
    drive(1, 1, 0, 0, 0, 1, 5, 0, 0);
    check("R6 stall while freeing", stall, 1);
    drive(1, 1, 0, 0, 0, 1, 7, 0, 0);
    check("R6 freed alloc", dst_p, 5);
    check("R6 freed ack", ack, 1);
    drive(1, 1, 0, 0, 0, 0, 0, 0, 0);
    check("R6 same cycle free", dst_p, 7);
    check("R6 same cycle ack", ack, 1);
    drive(1, 1, 2, 0, 0, 0, 0, 0, 0);
    check("R6 empty again", stall, 1);

    // checkpoint and restore
    do_reset();
    drive(1, 1, 3, 0, 0, 0, 0, 1, 0);
    check("R7 ckpt alloc", dst_p, 32);
    drive(1, 1, 3, 0, 0, 0, 0, 0, 0);
    check("R3 remap dst", dst_p, 33);
    check("R3 remap old", old_p, 32);
    drive(1, 1, 5, 0, 0, 0, 0, 0, 0);
    check("R3 dst5", dst_p, 34);
    drive(0, 0, 0, 0, 0, 1, 3, 0, 0);
    drive(1, 1, 6, 0, 0, 0, 0, 0, 1);
    check("R8 restore rejects", ack, 0);
    drive(1, 1, 7, 3, 5, 0, 0, 0, 0);
    check("R7 restored src1", src1_p, 32);
    check("R8 restored src2", src2_p, 5);
    check("R8 kept release", dst_p, 3);
    check("R8 old after restore", old_p, 7);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0);

    finish_run();
  end
endmodule